// File: doc/BRIEF.md
# Floppy Controller Status Register B

This block produces the second status register of a floppy disk controller. It samples the drive-interface pins into the system clock domain and keeps edge-driven state for the read-data and write-data streams. A mode input picks one of two read layouts. The normal layout shows the motor enables, the write gate, two toggle bits and a drive-select mirror. The compatibility layout shows the four drive selects and a drive-2 indication, all active low, and three sticky event flags.

The host bus decoder drives `rd_stb` while this register is being read and drives `dir_rd` for one cycle whenever the digital input register is read. That second read clears the sticky flags. The block holds no other registers.

Every asynchronous pin passes through a synchronizer with `SYNC_STAGES` flops. A level change on a pin therefore reaches the output `SYNC_STAGES` clocks later. Edge-driven bits take one clock more. Read data and write data are active low, so their inactive edge is the low-to-high transition.

Top module: `fdc_status_b`

## Requirements
- R1: While `rd_stb` is low, `rd_data` is all zero. While it is high, `rd_data` shows the layout chosen by `mode_compat` with no added delay.
- R2: In the normal layout (`mode_compat`=0), bit 0 is `mtr0`, bit 1 is `mtr1` and bit 2 is `wgate`, all active high. Each appears two clocks after the pin changes.
- R3: In the normal layout, bit 3 inverts on every low-to-high transition of `rdata_n` and bit 4 inverts on every low-to-high transition of `wdata_n`. High-to-low transitions leave them unchanged.
- R4: In the normal layout, bit 5 is `dor_ds0` registered once, and bits 7 and 6 read 1.
- R5: In the compatibility layout (`mode_compat`=1), bit 0 is `ds_n[2]`, bit 1 is `ds_n[3]`, bit 5 is `ds_n[0]`, bit 6 is `ds_n[1]` and bit 7 is `drv2_n`, each synchronized and shown at its pin level.
- R6: In the compatibility layout, bit 2 is set by a low-to-high transition of `wgate`. Bit 3 is set by a low-to-high transition of `rdata_n`. Bit 4 is set by a low-to-high transition of `wdata_n`, whatever the level of `wgate`. A one-cycle `dir_rd` pulse clears all three.
- R7: If a flag-setting transition and a clearing pulse arrive in the same cycle, the flag ends up set.
- R8: While `hw_rst` is high, the normal-layout bits 5..0 are 0 and the compatibility-layout bits 6..0 are 1,1,0,0,0,1,1 (bit 6 first). The toggle bits and flags restart from 0.
- R9: A `sw_rst` pulse clears the three sticky flags. It leaves the motor-enable bits, the drive-select mirror, the toggle bits and the pin levels unchanged.
- R10: With `COMPAT_EN`=0, `mode_compat` is ignored and `rd_data` always shows the normal layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset pulse, active high |
| mode_compat | input | 1 | 0 selects the normal layout, 1 the compatibility layout |
| rd_stb | input | 1 | High while this register is read |
| dir_rd | input | 1 | One-cycle pulse on a read of the digital input register |
| dor_ds0 | input | 1 | Drive-select bit 0 of the digital output register |
| mtr0 | input | 1 | Motor enable 0 pin, active high |
| mtr1 | input | 1 | Motor enable 1 pin, active high |
| wgate | input | 1 | Write gate pin, active high |
| rdata_n | input | 1 | Read data pin, active low |
| wdata_n | input | 1 | Write data pin, active low |
| ds_n | input | 4 | Drive select pins 3..0, active low |
| drv2_n | input | 1 | Drive-2 indication pin, active low |
| rd_data | output | 8 | Register read value |

## Verification
The bench drives random pin patterns that include falling edges, which must not count. A design that triggers on the wrong edge would let the toggle bits and flags drift away from the model. A directed case places a new read-data edge in exactly the cycle the clearing pulse arrives. A design that lets the clear win would lose that event, and bit 3 of the compatibility layout would read 0. Software-reset pulses and a mid-run hardware reset with pins held active test the split between the two resets. A design that cleared the toggles or the drive-select mirror on software reset, or that reset its synchronizers to active levels and so raised false edges, would show wrong bits after the pulse. A second instance built without the compatibility layout shows whether the mode input is really ignored.

// File: rtl/fdc_srb_pkg.sv
package fdc_srb_pkg;

   localparam int PIN_W   = 10;
   localparam int VIEW_W  = 8;
   localparam int EVT_N   = 3;
   localparam int TGL_N   = 2;

   // event channel order inside the edge vector
   localparam int EVT_WG  = 0;
   localparam int EVT_RD  = 1;
   localparam int EVT_WD  = 2;

   typedef struct packed {
      logic       drv2_n;
      logic [3:0] ds_n;
      logic       wdata_n;
      logic       rdata_n;
      logic       wgate;
      logic       mtr1;
      logic       mtr0;
   } fdc_pins_t;

   // inactive level of every pin; synchronizers restart here so no false edge appears
   localparam fdc_pins_t PINS_IDLE = '{
      drv2_n : 1'b1,
      ds_n   : 4'hF,
      wdata_n: 1'b1,
      rdata_n: 1'b1,
      wgate  : 1'b0,
      mtr1   : 1'b0,
      mtr0   : 1'b0
   };

   // idle level of {wdata_n, rdata_n, wgate}
   localparam logic [EVT_N-1:0] EVT_IDLE = 3'b110;

   typedef enum logic {
      LAYOUT_NORMAL = 1'b0,
      LAYOUT_COMPAT = 1'b1
   } fdc_layout_e;

endpackage

// File: rtl/fdc_srb_sync.sv
module fdc_srb_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $fatal(1, "fdc_srb_sync: STAGES below 2");
      assert (W >= 1)      else $fatal(1, "fdc_srb_sync: W below 1");
   end

   logic [W-1:0] chain [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= RST_VAL;
               else     chain[gi] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= RST_VAL;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fdc_srb_edge.sv
module fdc_srb_edge #(
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= RST_VAL;
      else     prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

endmodule

// File: rtl/fdc_srb_toggle.sv
module fdc_srb_toggle #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] evt,
   output logic [N-1:0] tgl
);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst)          tgl[gi] <= 1'b0;
            else if (evt[gi]) tgl[gi] <= ~tgl[gi];
         end
      end
   endgenerate

endmodule

// File: rtl/fdc_srb_sticky.sv
module fdc_srb_sticky #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] flag
);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         // a set in the clearing cycle survives
         always_ff @(posedge clk) begin
            if (rst)          flag[gi] <= 1'b0;
            else if (set[gi]) flag[gi] <= 1'b1;
            else if (clr)     flag[gi] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/fdc_status_b.sv
module fdc_status_b
   import fdc_srb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit COMPAT_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       hw_rst,
   input  logic       sw_rst,
   input  logic       mode_compat,
   input  logic       rd_stb,
   input  logic       dir_rd,
   input  logic       dor_ds0,
   input  logic       mtr0,
   input  logic       mtr1,
   input  logic       wgate,
   input  logic       rdata_n,
   input  logic       wdata_n,
   input  logic [3:0] ds_n,
   input  logic       drv2_n,
   output logic [7:0] rd_data
);

   initial begin
      assert (SYNC_STAGES >= 2) else $fatal(1, "fdc_status_b: SYNC_STAGES below 2");
      assert (VIEW_W == 8)      else $fatal(1, "fdc_status_b: view width must be 8");
   end

   fdc_pins_t         pins_raw;
   fdc_pins_t         pins_s;
   logic [PIN_W-1:0]  pins_s_vec;
   logic [EVT_N-1:0]  evt_lvl;
   logic [EVT_N-1:0]  evt_rise;
   logic [TGL_N-1:0]  tgls;
   logic [EVT_N-1:0]  flags;
   logic              dor_q;
   logic [VIEW_W-1:0] norm_view;
   logic [VIEW_W-1:0] cmp_view;
   logic [VIEW_W-1:0] sel_view;
   fdc_layout_e       layout;

   always_comb begin
      pins_raw.drv2_n  = drv2_n;
      pins_raw.ds_n    = ds_n;
      pins_raw.wdata_n = wdata_n;
      pins_raw.rdata_n = rdata_n;
      pins_raw.wgate   = wgate;
      pins_raw.mtr1    = mtr1;
      pins_raw.mtr0    = mtr0;
   end

   fdc_srb_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PINS_IDLE)
   ) u_sync (
      .clk(clk),
      .rst(hw_rst),
      .d  (pins_raw),
      .q  (pins_s_vec)
   );

   assign pins_s  = fdc_pins_t'(pins_s_vec);
   assign evt_lvl = {pins_s.wdata_n, pins_s.rdata_n, pins_s.wgate};

   fdc_srb_edge #(
      .W      (EVT_N),
      .RST_VAL(EVT_IDLE)
   ) u_edge (
      .clk (clk),
      .rst (hw_rst),
      .lvl (evt_lvl),
      .rise(evt_rise)
   );

   fdc_srb_toggle #(.N(TGL_N)) u_tgl (
      .clk(clk),
      .rst(hw_rst),
      .evt({evt_rise[EVT_WD], evt_rise[EVT_RD]}),
      .tgl(tgls)
   );

   always_ff @(posedge clk) begin
      if (hw_rst) dor_q <= 1'b0;
      else        dor_q <= dor_ds0;
   end

   assign norm_view = {2'b11, dor_q, tgls[1], tgls[0],
                       pins_s.wgate, pins_s.mtr1, pins_s.mtr0};

   generate
      if (COMPAT_EN) begin : g_compat
         fdc_srb_sticky #(.N(EVT_N)) u_flags (
            .clk (clk),
            .rst (hw_rst),
            .set (evt_rise),
            .clr (dir_rd | sw_rst),
            .flag(flags)
         );
         assign cmp_view = {pins_s.drv2_n, pins_s.ds_n[1], pins_s.ds_n[0],
                            flags[EVT_WD], flags[EVT_RD], flags[EVT_WG],
                            pins_s.ds_n[3], pins_s.ds_n[2]};
         assign layout   = fdc_layout_e'(mode_compat);
      end else begin : g_normal_only
         assign flags    = '0;
         assign cmp_view = '0;
         assign layout   = LAYOUT_NORMAL;
      end
   endgenerate

   always_comb begin
      unique case (layout)
         LAYOUT_COMPAT: sel_view = cmp_view;
         default:       sel_view = norm_view;
      endcase
   end

   assign rd_data = rd_stb ? sel_view : '0;

endmodule

// File: rtl/fdc_status_b_chk.sv
module fdc_status_b_chk #(
   parameter bit COMPAT_EN = 1'b1
) (
   input logic       clk,
   input logic       hw_rst,
   input logic       sw_rst,
   input logic       mode_compat,
   input logic       rd_stb,
   input logic       dir_rd,
   input logic [7:0] rd_data,
   input logic [2:0] evt_rise,
   input logic [1:0] tgls,
   input logic [2:0] flags,
   input logic [7:0] norm_view,
   input logic [7:0] cmp_view
);

   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (hw_rst)
      !rd_stb |-> rd_data == 8'h00);

   // R4
   resv_ones_chk: assert property (@(posedge clk) disable iff (hw_rst)
      (rd_stb && (!mode_compat || !COMPAT_EN)) |-> rd_data[7:6] == 2'b11);

   // R3
   rd_toggle_chk: assert property (@(posedge clk) disable iff (hw_rst)
      evt_rise[1] |=> tgls[0] != $past(tgls[0]));

   // R3
   wd_toggle_chk: assert property (@(posedge clk) disable iff (hw_rst)
      evt_rise[2] |=> tgls[1] != $past(tgls[1]));

   // R9
   swrst_keep_chk: assert property (@(posedge clk) disable iff (hw_rst)
      (sw_rst && evt_rise == 3'b000) |=> $stable(tgls));

   // R8
   reset_view_chk: assert property (@(posedge clk) disable iff (hw_rst)
      $fell(hw_rst) |-> (norm_view[5:0] == 6'd0 &&
                         (!COMPAT_EN || cmp_view[6:0] == 7'b1100011)));

   generate
      if (COMPAT_EN) begin : g_flag_chk
         // R7
         flag_set_chk: assert property (@(posedge clk) disable iff (hw_rst)
            (evt_rise != 3'b000) |=> (flags & $past(evt_rise)) == $past(evt_rise));

         // R6
         flag_clr_chk: assert property (@(posedge clk) disable iff (hw_rst)
            ((dir_rd || sw_rst) && evt_rise == 3'b000) |=> flags == 3'b000);
      end
   endgenerate

endmodule

bind fdc_status_b fdc_status_b_chk #(.COMPAT_EN(COMPAT_EN)) u_chk (
   .clk        (clk),
   .hw_rst     (hw_rst),
   .sw_rst     (sw_rst),
   .mode_compat(mode_compat),
   .rd_stb     (rd_stb),
   .dir_rd     (dir_rd),
   .rd_data    (rd_data),
   .evt_rise   (evt_rise),
   .tgls       (tgls),
   .flags      (flags),
   .norm_view  (norm_view),
   .cmp_view   (cmp_view)
);

// File: tb/fdc_status_b_tb.sv
module fdc_status_b_tb;

   logic       clk = 1'b0;
   logic       hw_rst = 1'b1;
   logic       sw_rst = 1'b0;
   logic       mode_compat = 1'b0;
   logic       rd_stb = 1'b0;
   logic       dir_rd = 1'b0;
   logic       dor_ds0 = 1'b0;
   logic       mtr0 = 1'b0;
   logic       mtr1 = 1'b0;
   logic       wgate = 1'b0;
   logic       rdata_n = 1'b1;
   logic       wdata_n = 1'b1;
   logic [3:0] ds_n = 4'hF;
   logic       drv2_n = 1'b1;
   logic [7:0] rd_data;
   logic [7:0] rd_data_nc;

   int errors = 0;
   int checks = 0;

   // bench model
   logic p_wg = 1'b0, p_rd = 1'b1, p_wd = 1'b1;
   logic m_trd = 1'b0, m_twd = 1'b0;
   logic m_fwg = 1'b0, m_frd = 1'b0, m_fwd = 1'b0;
   logic m_dor = 1'b0;

   always #10 clk = ~clk;

   fdc_status_b u_dut (
      .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .mode_compat(mode_compat),
      .rd_stb(rd_stb), .dir_rd(dir_rd), .dor_ds0(dor_ds0), .mtr0(mtr0),
      .mtr1(mtr1), .wgate(wgate), .rdata_n(rdata_n), .wdata_n(wdata_n),
      .ds_n(ds_n), .drv2_n(drv2_n), .rd_data(rd_data)
   );

   fdc_status_b #(.COMPAT_EN(1'b0)) u_dut_nc (
      .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .mode_compat(mode_compat),
      .rd_stb(rd_stb), .dir_rd(dir_rd), .dor_ds0(dor_ds0), .mtr0(mtr0),
      .mtr1(mtr1), .wgate(wgate), .rdata_n(rdata_n), .wdata_n(wdata_n),
      .ds_n(ds_n), .drv2_n(drv2_n), .rd_data(rd_data_nc)
   );

   function automatic logic [7:0] exp_norm();
      return {2'b11, m_dor, m_twd, m_trd, wgate, mtr1, mtr0};
   endfunction

   function automatic logic [7:0] exp_cmp();
      return {drv2_n, ds_n[1], ds_n[0], m_fwd, m_frd, m_fwg, ds_n[3], ds_n[2]};
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic apply_edges();
      if (!p_wg && wgate)   m_fwg = 1'b1;
      if (!p_rd && rdata_n) begin m_frd = 1'b1; m_trd = ~m_trd; end
      if (!p_wd && wdata_n) begin m_fwd = 1'b1; m_twd = ~m_twd; end
      p_wg = wgate; p_rd = rdata_n; p_wd = wdata_n;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_views(input string tag);
      rd_stb = 1'b1;
      mode_compat = 1'b0;
      #1;
      chk({tag, " R2 R3 R4 normal"}, rd_data, exp_norm());
      chk({tag, " R10 normal-only"}, rd_data_nc, exp_norm());
      mode_compat = 1'b1;
      #1;
      chk({tag, " R5 R6 compat"}, rd_data, exp_cmp());
      chk({tag, " R10 mode ignored"}, rd_data_nc, exp_norm());
      rd_stb = 1'b0;
      #1;
      chk({tag, " R1 idle"}, rd_data, 8'h00);
   endtask

   task automatic pulse(input bit use_sw);
      if (use_sw) sw_rst = 1'b1; else dir_rd = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      dir_rd = 1'b0;
      m_fwg = 1'b0; m_frd = 1'b0; m_fwd = 1'b0;
   endtask

   task automatic check_reset_state(input string tag);
      rd_stb = 1'b1;
      mode_compat = 1'b0;
      #1;
      chk({tag, " R8 normal reset"}, {2'b00, rd_data[5:0]}, 8'h00);
      mode_compat = 1'b1;
      #1;
      chk({tag, " R8 compat reset"}, {1'b0, rd_data[6:0]}, 8'b0110_0011);
      rd_stb = 1'b0;
   endtask

   task automatic model_reset();
      m_trd = 1'b0; m_twd = 1'b0;
      m_fwg = 1'b0; m_frd = 1'b0; m_fwd = 1'b0;
      p_wg = 1'b0; p_rd = 1'b1; p_wd = 1'b1;
   endtask

   task automatic rand_pins();
      logic [31:0] r;
      r = $urandom;
      mtr0 = r[0]; mtr1 = r[1]; wgate = r[2]; rdata_n = r[3];
      wdata_n = r[4]; ds_n = r[8:5]; drv2_n = r[9]; dor_ds0 = r[10];
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset_state("init");
      hw_rst = 1'b0;
      model_reset();
      settle();
      check_views("post-reset");

      // R3 directed: several read-data pulses, falling edges must not count
      for (int i = 0; i < 3; i++) begin
         rdata_n = 1'b0; apply_edges(); settle();
         check_views("R3 falling");
         rdata_n = 1'b1; apply_edges(); settle();
         check_views("R3 rising");
      end

      // R6 directed: write-data flag with write gate low, then clear
      wgate = 1'b0;
      wdata_n = 1'b0; apply_edges(); settle();
      wdata_n = 1'b1; apply_edges(); settle();
      check_views("R6 wdata no gate");
      pulse(1'b0);
      check_views("R6 cleared");

      // R7 directed: edge reaches the flag in the clearing cycle
      rdata_n = 1'b0; apply_edges(); settle();
      pulse(1'b0);
      rdata_n = 1'b1;
      apply_edges();
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      dir_rd = 1'b1;
      @(negedge clk);
      dir_rd = 1'b0;
      m_fwg = 1'b0; m_fwd = 1'b0;
      settle();
      rd_stb = 1'b1; mode_compat = 1'b1; #1;
      chk("R7 set wins", {7'd0, rd_data[3]}, 8'h01);
      rd_stb = 1'b0;
      check_views("R7 after");

      // R9 directed: toggles, motors and mirror survive a software reset
      mtr0 = 1'b1; mtr1 = 1'b1; dor_ds0 = 1'b1; wgate = 1'b1;
      apply_edges(); m_dor = 1'b1; settle();
      pulse(1'b1);
      check_views("R9 sw reset");

      // random phase
      for (int step = 0; step < 400; step++) begin
         logic [1:0] act;
         rand_pins();
         apply_edges();
         m_dor = dor_ds0;
         settle();
         check_views("rand");
         act = 2'($urandom % 4);
         if (act == 2'd0) begin
            pulse(1'b0);
            check_views("rand R6 clear");
         end else if (act == 2'd1) begin
            pulse(1'b1);
            check_views("rand R9 sw");
         end
         if (step == 200) begin
            // R8 mid-run hardware reset with pins left where they are
            @(negedge clk);
            hw_rst = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check_reset_state("mid");
            hw_rst = 1'b0;
            model_reset();
            m_dor = 1'b0;
            apply_edges();
            m_dor = dor_ds0;
            settle();
            check_views("R8 after mid reset");
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule